// File: doc/BRIEF.md
# Thermal Status Register with Sticky Change Flag

This block models, on the memory-device side, the one mode register that reports die temperature. A 3-bit refresh-rate code arrives from an on-chip sensor. The block does not follow that code on every clock. It takes a new sample only at update points spaced a fixed number of clock cycles apart, which stands in for the sensor's 32 ms maximum refresh interval. The held code is exposed in an 8-bit read word.

The top bit of the word is a sticky indicator. It goes high whenever an update point brings in a code different from the one held, and it stays high until the register is read. A host that polls the register can therefore tell whether the temperature band moved at any time since its previous read, even if the code has since moved back.

The update period is a parameter counted in clock cycles. A simulation can use a small value, and silicon can use the cycle count for 32 ms.

Top module: `thermal_status_reg`

## Requirements
- R1: With `rst_n` low at a rising edge (synchronous, active low), the register returns to flag 0 and code `RESET_CODE` (default 3'b011), so `rd_data` reads 8'h03 with default parameters. The update-point counter also restarts.
- R2: `rd_data` is laid out as follows. Bit 7 is the change flag. Bits 6..3 always read 0. Bits 2..0 are the held code, passed through unaltered. The code values are: 3'b000 below the low-temperature limit; 3'b001 four-times refresh; 3'b010 two-times; 3'b011 nominal one-times; 3'b100 reserved; 3'b101 quarter interval without timing derating; 3'b110 quarter interval with timing derating; 3'b111 above the maximum temperature.
- R3: The sensor code is sampled only at update points. These are the rising edges numbered `UPDATE_CYCLES`, 2×`UPDATE_CYCLES`, and so on, counting from the first edge with `rst_n` high. Between update points the held code does not change.
- R4: If the code sampled at an update point differs from the held code, the flag is 1 after that edge.
- R5: Once set, the flag stays 1 across any number of update points, with or without further changes, until a read.
- R6: A cycle with `rd_stb` high clears the flag at its closing edge, unless R7 applies.
- R7: If `rd_stb` is high in the same cycle as an update point that brings a changed code, `rd_data` in that cycle shows the old flag and old code. After the edge the flag is 1 and the new code is held.
- R8: A sensor code that departs and returns before the next update point leaves both the code and the flag untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| sensor_code | input | 3 | Raw refresh-rate code from the on-chip sensor |
| rd_stb | input | 1 | Register-read strobe, one cycle per read |
| rd_data | output | 8 | Register contents: {flag, 4'b0000, code} |

## Verification
`rd_data` is a combinational view of two registers. A read or an update point therefore shows on it immediately after the edge that closes the cycle concerned, and a read strobe never changes the word seen during its own cycle. With an update period of 4, the bench starts every stimulus block on the falling edge after reset release and holds it for exactly four edges, so the last edge of each block is an update point. The bench compares `rd_data` on the falling edge that follows. The same-cycle case and the mid-period check sample on the falling edge inside the cycle, before the edge that would change the value.

// File: rtl/thermal_pkg.sv
// Package: shared widths, bit positions and the refresh-rate code type
// for the thermal status register.
// Assumes: a 3-bit code field in the low bits and the flag in the top bit.
package thermal_pkg;

    localparam int CODE_W   = 3;
    localparam int REG_W    = 8;
    localparam int FLAG_BIT = REG_W - 1;
    localparam int PAD_W    = REG_W - CODE_W - 1;

    typedef enum logic [CODE_W-1:0] {
        TC_TOO_COLD    = 3'b000,
        TC_REFRESH_X4  = 3'b001,
        TC_REFRESH_X2  = 3'b010,
        TC_REFRESH_X1  = 3'b011,
        TC_RESERVED    = 3'b100,
        TC_QUARTER     = 3'b101,
        TC_QUARTER_DRT = 3'b110,
        TC_TOO_HOT     = 3'b111
    } therm_code_e;

    // Assemble the visible register word from flag and code.
    function automatic logic [REG_W-1:0] pack_word(input logic flag,
                                                   input therm_code_e code);
        return {flag, {PAD_W{1'b0}}, code};
    endfunction

endpackage

// File: rtl/tsr_update_timer.sv
// Module: tsr_update_timer
// Issues a one-cycle update pulse on every UPDATE_CYCLES-th clock after
// reset release.
// Assumes: UPDATE_CYCLES >= 2; reset is synchronous and active low.
module tsr_update_timer #(
    parameter int UPDATE_CYCLES = 3_200_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CNT_W = (UPDATE_CYCLES > 2) ? $clog2(UPDATE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UPDATE_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles within the period, wrapping on the final one.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);

    // R3: update points are isolated pulses, never back to back.
    a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/tsr_code_sampler.sv
// Module: tsr_code_sampler
// Holds the refresh-rate code. Loads the sensor value only on an update
// pulse and reports whether that load changes the held value.
// Assumes: sensor_code is already synchronous to clk.
module tsr_code_sampler
    import thermal_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CODE_W-1:0] sensor_code,
    output therm_code_e       code_q,
    output logic              code_chg
);

    // Capture the sensor code at update points only.
    always_ff @(posedge clk) begin
        if (!rst_n)    code_q <= therm_code_e'(RESET_CODE);
        else if (tick) code_q <= therm_code_e'(sensor_code);
    end

    assign code_chg = tick && (sensor_code != code_q);

    // R3 / R8: the held code only moves on an update point.
    a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(code_q));

endmodule

// File: rtl/tsr_change_flag.sv
// Module: tsr_change_flag
// Sticky change indicator. It is set by a code change, cleared by a read,
// and the change wins when both happen in one cycle.
// Assumes: code_chg and rd_stb are single-cycle qualified events.
module tsr_change_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic code_chg,
    input  logic rd_stb,
    output logic flag_q
);

    // Set on change, clear on read, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (code_chg) flag_q <= 1'b1;
        else if (rd_stb)   flag_q <= 1'b0;
    end

    // R4 / R7: a change always leaves the flag set, even under a read.
    a_r4_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        code_chg |=> flag_q);

    // R5: without a read the flag never falls.
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !rd_stb) |=> flag_q);

    // R6: a read with no coincident change clears the flag.
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !code_chg) |=> !flag_q);

    // R4: the flag only rises because of a change.
    a_r4_rise_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !code_chg) |=> !flag_q);

endmodule

// File: rtl/thermal_status_reg.sv
// Module: thermal_status_reg (top)
// Device-side temperature status register: a periodically sampled
// refresh-rate code plus a sticky changed-since-read flag.
// Assumes: synchronous active-low reset, with UPDATE_CYCLES in clk cycles.
module thermal_status_reg
    import thermal_pkg::*;
#(
    parameter int                UPDATE_CYCLES = 3_200_000,
    parameter logic [CODE_W-1:0] RESET_CODE    = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] sensor_code,
    input  logic              rd_stb,
    output logic [REG_W-1:0]  rd_data
);

    logic        tick;
    logic        code_chg;
    logic        flag_q;
    therm_code_e code_q;

    tsr_update_timer #(.UPDATE_CYCLES(UPDATE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tsr_code_sampler #(.RESET_CODE(RESET_CODE)) u_sampler (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .sensor_code (sensor_code),
        .code_q      (code_q),
        .code_chg    (code_chg)
    );

    tsr_change_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_chg (code_chg),
        .rd_stb   (rd_stb),
        .flag_q   (flag_q)
    );

    // Present the register word directly from the state registers.
    always_comb rd_data = pack_word(flag_q, code_q);

    // R2: the top bit tracks the flag across a read cycle without a change.
    a_r2_flag_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !tick) |=> (rd_data[FLAG_BIT] == 1'b0));

endmodule

// File: tb/test_thermal_status_reg.sv
// Bench for thermal_status_reg: a vector table of update-period blocks,
// then directed reset, glitch, mid-period and same-cycle read cases.
module test_thermal_status_reg;

    localparam int P = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sensor_code = 3'b011;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    thermal_status_reg #(.UPDATE_CYCLES(P), .RESET_CODE(3'b011)) i_thermal_status_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .sensor_code (sensor_code),
        .rd_stb      (rd_stb),
        .rd_data     (rd_data)
    );

    always #10 clk = ~clk;

    // Each entry: {code[3], read in first cycle[1], expected rd_data[8]}.
    localparam logic [11:0] VEC [13] = '{
        {3'b011, 1'b0, 8'h03},   // R3 no change, flag stays clear
        {3'b101, 1'b0, 8'h85},   // R4 change sets flag
        {3'b101, 1'b0, 8'h85},   // R5 sticky with no change
        {3'b101, 1'b1, 8'h05},   // R6 read clears
        {3'b110, 1'b0, 8'h86},   // R4
        {3'b111, 1'b0, 8'h87},   // R5 sticky across another change
        {3'b111, 1'b1, 8'h07},   // R6
        {3'b000, 1'b1, 8'h80},   // R4 read early, change later sets
        {3'b001, 1'b0, 8'h81},   // R2 code pass-through
        {3'b010, 1'b1, 8'h82},   // R2
        {3'b010, 1'b1, 8'h02},   // R6
        {3'b100, 1'b0, 8'h84},   // R2 reserved value passes unaltered
        {3'b100, 1'b1, 8'h04}    // R6
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: rd_data=%02h expected %02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // One update period, starting and ending on a falling edge.
    task automatic run_block(input logic [2:0] code, input logic rd_first);
        sensor_code = code;
        for (int c = 0; c < P; c++) begin
            rd_stb = (c == 0) && rd_first;
            @(posedge clk);
            @(negedge clk);
        end
        rd_stb = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check("R1 reset value", rd_data, 8'h03);

        for (int v = 0; v < 13; v++) begin
            run_block(VEC[v][11:9], VEC[v][8]);
            check($sformatf("vector %0d (R2-R6)", v), rd_data, VEC[v][7:0]);
        end

        // R8: a glitch that returns before the update point is ignored.
        sensor_code = 3'b000;
        for (int c = 0; c < P; c++) begin
            if (c == P - 1) sensor_code = 3'b100;
            @(posedge clk);
            @(negedge clk);
        end
        check("R8 glitch ignored", rd_data, 8'h04);

        // R3: mid-period the held code does not follow the sensor.
        sensor_code = 3'b110;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R3 no update mid-period", rd_data, 8'h04);
        sensor_code = 3'b100;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R3 update point", rd_data, 8'h04);

        // R7: a read coinciding with a changing update point.
        sensor_code = 3'b011;
        for (int c = 0; c < P - 1; c++) begin
            @(posedge clk);
            @(negedge clk);
        end
        rd_stb = 1'b1;
        #1;
        check("R7 read shows old word", rd_data, 8'h04);
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
        check("R7 flag set after coincident read", rd_data, 8'h83);

        // R1: reset in mid-run clears the flag and restores the code.
        sensor_code = 3'b110;
        do_reset();
        check("R1 mid-run reset", rd_data, 8'h03);
        run_block(3'b011, 1'b0);
        check("R1 counter restarted, no change", rd_data, 8'h03);
        run_block(3'b001, 1'b0);
        check("R1 first update point after reset", rd_data, 8'h81);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule